// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Unit

This block sits between a device's pins and its internal logic and implements a low-power freeze. When the power-down option is enabled and a dedicated control pin is held high, the block captures the input pin vector, the internal signal vector and the output data and enable vectors, and presents only those captured copies to the rest of the chip. Pin activity is ignored until the control pin returns low. The control pin passes through a two-flop synchronizer before it takes effect. With the option disabled, the control pin is an ordinary logic pin and the block is transparent.

A separate idle detector watches the gated input vector. After a configurable run of clock edges with no change, it raises an automatic standby flag. The flag drops in the same cycle in which any change appears. Reducing analog current is left to circuitry outside this block.

Top module: `pdhold_top`

## Requirements
- R1: With `pd_opt_en` low, `pd_active` stays 0 and every held output equals its live input in the same cycle, whatever `pd_pin` does.
- R2: With `pd_opt_en` high, `pd_active` is 1 from the second rising edge at which `pd_pin` has been sampled high, because of a two-stage synchronizer.
- R3: While `pd_active` is 1, `sig_held` equals `core_sig` as sampled at the last rising edge before `pd_active` became 1.
- R4: While `pd_active` is 1, `out_held` and `oe_held` keep the values captured at that same edge. An output that was enabled keeps driving its captured data.
- R5: While `pd_active` is 1, changes on `pin_in` do not reach `pin_held`.
- R6: When `pd_pin` returns low, `pd_active` falls at the second rising edge. In that same cycle, all held outputs follow their live inputs again.
- R7: With `pd_opt_en` high, `pd_logic_in` reads 0 and `pd_pad_oe` is 0 whatever `pd_pad_oe_req` is. With the option low, `pd_logic_in` equals `pd_pin` and `pd_pad_oe` equals `pd_pad_oe_req`.
- R8: `standby` goes to 1 once `pin_held` has matched its previous-edge value at IDLE_CYC consecutive rising edges, and it stays 1 while there is no change.
- R9: In any cycle where `pin_held` differs from its value at the previous edge, `standby` is 0. Counting then restarts from zero.
- R10: During and right after reset, `pd_active` is 0 and `standby` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_opt_en | input | 1 | Configuration bit enabling the power-down function |
| pd_pin | input | 1 | Power-down control pin, asynchronous |
| pd_pad_oe_req | input | 1 | Logic request to drive the control pin as an output |
| pin_in | input | IN_W | Live input pin vector |
| core_sig | input | SIG_W | Live internal signal vector |
| core_out | input | OUT_W | Live output data |
| core_oe | input | OUT_W | Live output enables |
| pin_held | output | IN_W | Input vector as seen by logic |
| sig_held | output | SIG_W | Internal signal vector, frozen in power-down |
| out_held | output | OUT_W | Output data, frozen in power-down |
| oe_held | output | OUT_W | Output enables, frozen in power-down |
| pd_logic_in | output | 1 | Control pin value offered to logic (0 when the option is on) |
| pd_pad_oe | output | 1 | Output enable for the control pin's pad |
| standby | output | 1 | Automatic standby flag |
| pd_active | output | 1 | Power-down in effect |

## Verification
The bench builds the block with IN_W=8, SIG_W=8, OUT_W=4 and IDLE_CYC=5. The short idle threshold lets standby assert, saturate and clear several times within a few dozen cycles, including inside a power-down window where frozen pins count as idle. The narrow vectors still let the bench give pins, signals, data and enables distinct patterns. A wrong capture edge or a missing enable bit therefore shows up as a mismatch.

// File: rtl/pdh_pkg.sv
// Shared constants for the power-down hold unit.
// Assumes: nothing beyond IEEE 1800-2017.
package pdh_pkg;
    // Synchronizer stages on the control pin
    localparam int unsigned SYNC_DEPTH = 2;

    // Width of a counter that must reach the value lim
    function automatic int unsigned cnt_width(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction
endpackage

// File: rtl/pdh_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: DEPTH >= 2; reset is synchronous and active low, and clears every stage.
module pdh_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] stg;

    // Shift the sampled level through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[DEPTH-2:0], d};
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/pdh_hold.sv
// Capture-and-hold for one vector. It tracks the live value while open and
// presents the copy from the last open edge while frozen.
// Assumes: freeze is synchronous to clk.
module pdh_hold #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         freeze,
    input  logic [W-1:0] live,
    output logic [W-1:0] held
);
    logic [W-1:0] cap;

    // Refresh the captured copy on every edge where the unit is not frozen
    always_ff @(posedge clk) begin
        if (!rst_n)       cap <= '0;
        else if (!freeze) cap <= live;
    end

    // Select the captured copy while frozen, else pass live through
    always_comb begin
        held = freeze ? cap : live;
    end
endmodule

// File: rtl/pdh_idle.sv
// Idle detector: counts consecutive edges with an unchanged vector and flags
// standby once the count reaches LIMIT. A change clears the flag at once.
// Assumes: LIMIT >= 1.
module pdh_idle #(
    parameter int unsigned W     = 8,
    parameter int unsigned LIMIT = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vec,
    output logic         standby
);
    import pdh_pkg::*;

    localparam int unsigned CW = cnt_width(LIMIT);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [W-1:0]  prev;
    logic [CW-1:0] cnt;
    logic          chg;

    // Detect a difference from the value seen at the previous edge
    always_comb begin
        chg = |(vec ^ prev);
    end

    // Track the previous value and the saturating run length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            cnt  <= '0;
        end else begin
            prev <= vec;
            if (chg)             cnt <= '0;
            else if (cnt != LIM) cnt <= cnt + 1'b1;
        end
    end

    // Raise standby only when the run is long enough and nothing changes now
    always_comb begin
        standby = (cnt == LIM) && !chg;
    end
endmodule

// File: rtl/pdhold_top.sv
// Top of the power-down hold unit. It synchronizes the control pin, qualifies
// it with the option bit, and freezes the pin, signal and output vectors while
// power-down is in effect. It also removes the control pin from logic use when
// the option is on, and drives the idle-based standby flag.
// Assumes: single clock domain; only pd_pin is asynchronous.
module pdhold_top #(
    parameter int unsigned IN_W     = 8,
    parameter int unsigned SIG_W    = 8,
    parameter int unsigned OUT_W    = 4,
    parameter int unsigned IDLE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_opt_en,
    input  logic             pd_pin,
    input  logic             pd_pad_oe_req,
    input  logic [IN_W-1:0]  pin_in,
    input  logic [SIG_W-1:0] core_sig,
    input  logic [OUT_W-1:0] core_out,
    input  logic [OUT_W-1:0] core_oe,
    output logic [IN_W-1:0]  pin_held,
    output logic [SIG_W-1:0] sig_held,
    output logic [OUT_W-1:0] out_held,
    output logic [OUT_W-1:0] oe_held,
    output logic             pd_logic_in,
    output logic             pd_pad_oe,
    output logic             standby,
    output logic             pd_active
);
    import pdh_pkg::*;

    localparam int unsigned OUTV_W = 2 * OUT_W;

    logic              pd_sync;
    logic              frozen;
    logic [OUTV_W-1:0] outv_live;
    logic [OUTV_W-1:0] outv_held;

    pdh_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pd_pin),
        .q     (pd_sync)
    );

    // Qualify the synchronized request with the option bit
    always_comb begin
        frozen = pd_opt_en && pd_sync;
    end

    pdh_hold #(.W(IN_W)) u_hold_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (frozen),
        .live   (pin_in),
        .held   (pin_held)
    );

    pdh_hold #(.W(SIG_W)) u_hold_sig (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (frozen),
        .live   (core_sig),
        .held   (sig_held)
    );

    // Pack output data and enables so that one hold unit captures both together
    always_comb begin
        outv_live = {core_oe, core_out};
    end

    pdh_hold #(.W(OUTV_W)) u_hold_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (frozen),
        .live   (outv_live),
        .held   (outv_held)
    );

    // Unpack the held output data and enables
    always_comb begin
        out_held = outv_held[OUT_W-1:0];
        oe_held  = outv_held[OUTV_W-1:OUT_W];
    end

    pdh_idle #(.W(IN_W), .LIMIT(IDLE_CYC)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .vec     (pin_held),
        .standby (standby)
    );

    // Remove the control pin from logic use when the option is on
    always_comb begin
        pd_logic_in = pd_opt_en ? 1'b0 : pd_pin;
        pd_pad_oe   = pd_opt_en ? 1'b0 : pd_pad_oe_req;
        pd_active   = frozen;
    end
endmodule

// File: rtl/pdhold_chk.sv
// Property checker for pdhold_top, attached by bind.
module pdhold_chk #(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned SIG_W = 8,
    parameter int unsigned OUT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pd_opt_en,
    input logic             pd_pin,
    input logic [IN_W-1:0]  pin_held,
    input logic [SIG_W-1:0] sig_held,
    input logic [OUT_W-1:0] out_held,
    input logic [OUT_W-1:0] oe_held,
    input logic             standby,
    input logic             pd_active
);
    // R1: no power-down without the option
    a_r1_opt_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_opt_en |-> !pd_active);

    // R2: power-down needs the pin high two edges back
    a_r2_sync_entry: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> $past(pd_pin, 2));

    // R3: internal signals frozen across consecutive power-down cycles
    a_r3_sig_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && $past(pd_active)) |-> $stable(sig_held));

    // R4: output data and enables frozen
    a_r4_out_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && $past(pd_active)) |-> ($stable(out_held) && $stable(oe_held)));

    // R5: pins ignored while frozen
    a_r5_pins_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && $past(pd_active)) |-> $stable(pin_held));

    // R6: pin low two edges back releases power-down
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pd_pin, 2) |-> !pd_active);

    // R9: a visible pin change forces standby low
    a_r9_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_held != $past(pin_held)) |-> !standby);
endmodule

bind pdhold_top pdhold_chk #(
    .IN_W  (IN_W),
    .SIG_W (SIG_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_opt_en (pd_opt_en),
    .pd_pin    (pd_pin),
    .pin_held  (pin_held),
    .sig_held  (sig_held),
    .out_held  (out_held),
    .oe_held   (oe_held),
    .standby   (standby),
    .pd_active (pd_active)
);

// File: tb/tb_pdhold_top.sv
// Scoreboard bench for pdhold_top. A driver task applies stimulus at the
// falling edge and queues the expected outputs; a monitor pops and compares.
module tb_pdhold_top;
    localparam int IN_W = 8, SIG_W = 8, OUT_W = 4, IDLE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_opt_en = 1'b0, pd_pin = 1'b0, pd_pad_oe_req = 1'b0;
    logic [IN_W-1:0]  pin_in = '0;
    logic [SIG_W-1:0] core_sig = '0;
    logic [OUT_W-1:0] core_out = '0, core_oe = '0;
    logic [IN_W-1:0]  pin_held;
    logic [SIG_W-1:0] sig_held;
    logic [OUT_W-1:0] out_held, oe_held;
    logic pd_logic_in, pd_pad_oe, standby, pd_active;

    always #5 clk = ~clk;

    pdhold_top #(.IN_W(IN_W), .SIG_W(SIG_W), .OUT_W(OUT_W), .IDLE_CYC(IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .pd_opt_en(pd_opt_en), .pd_pin(pd_pin),
        .pd_pad_oe_req(pd_pad_oe_req), .pin_in(pin_in), .core_sig(core_sig),
        .core_out(core_out), .core_oe(core_oe), .pin_held(pin_held),
        .sig_held(sig_held), .out_held(out_held), .oe_held(oe_held),
        .pd_logic_in(pd_logic_in), .pd_pad_oe(pd_pad_oe), .standby(standby),
        .pd_active(pd_active)
    );

    typedef struct {
        string            tag;
        logic [IN_W-1:0]  pin;
        logic [SIG_W-1:0] sig;
        logic [OUT_W-1:0] dout;
        logic [OUT_W-1:0] oe;
        logic             lin, poe, sb, act;
    } exp_t;

    exp_t q[$];
    event ev_chk;
    int total = 0, bad = 0;
    bit done = 0;

    // Behavioural model state, derived from the requirements
    logic m_s1, m_s2;
    logic [IN_W-1:0]  m_pin, m_prev;
    logic [SIG_W-1:0] m_sig;
    logic [OUT_W-1:0] m_out, m_oe;
    int m_cnt;

    // Advance the model at each rising edge
    always @(posedge clk) begin
        logic fz;
        logic [IN_W-1:0] g;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_pin = '0; m_prev = '0;
            m_sig = '0; m_out = '0; m_oe = '0; m_cnt = 0;
        end else begin
            fz = pd_opt_en && m_s2;
            g  = fz ? m_pin : pin_in;
            if (g != m_prev) m_cnt = 0;
            else if (m_cnt < IDLE) m_cnt = m_cnt + 1;
            m_prev = g;
            if (!fz) begin
                m_pin = pin_in; m_sig = core_sig; m_out = core_out; m_oe = core_oe;
            end
            m_s2 = m_s1;
            m_s1 = pd_pin;
        end
    end

    task automatic cmp(string tag, string fld, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    // Monitor: pop expected items and compare against the ports
    initial begin
        forever begin
            @(ev_chk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "pin_held", 16'(pin_held), 16'(e.pin));
                cmp(e.tag, "sig_held", 16'(sig_held), 16'(e.sig));
                cmp(e.tag, "out_held", 16'(out_held), 16'(e.dout));
                cmp(e.tag, "oe_held", 16'(oe_held), 16'(e.oe));
                cmp(e.tag, "pd_logic_in", 16'(pd_logic_in), 16'(e.lin));
                cmp(e.tag, "pd_pad_oe", 16'(pd_pad_oe), 16'(e.poe));
                cmp(e.tag, "standby", 16'(standby), 16'(e.sb));
                cmp(e.tag, "pd_active", 16'(pd_active), 16'(e.act));
            end
        end
    end

    // Driver: apply one cycle of stimulus and queue its expected outputs
    task automatic step(string tag, logic opt, logic pdp, logic req,
                        logic [IN_W-1:0] p, logic [SIG_W-1:0] s,
                        logic [OUT_W-1:0] o, logic [OUT_W-1:0] e);
        exp_t x;
        logic fz;
        @(negedge clk);
        pd_opt_en = opt; pd_pin = pdp; pd_pad_oe_req = req;
        pin_in = p; core_sig = s; core_out = o; core_oe = e;
        #1;
        fz     = opt && m_s2;
        x.tag  = tag;
        x.pin  = fz ? m_pin : p;
        x.sig  = fz ? m_sig : s;
        x.dout = fz ? m_out : o;
        x.oe   = fz ? m_oe : e;
        x.lin  = opt ? 1'b0 : pdp;
        x.poe  = opt ? 1'b0 : req;
        x.sb   = (m_cnt >= IDLE) && (x.pin == m_prev);
        x.act  = fz;
        q.push_back(x);
        -> ev_chk;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R10: reset state while reset is held
        @(negedge clk);
        cmp("R10", "pd_active", 16'(pd_active), 16'd0);
        cmp("R10", "standby", 16'(standby), 16'd0);
        rst_n = 1'b1;
        step("R10", 0, 0, 0, 8'h00, 8'h00, 4'h0, 4'h0);

        // R1 and R7: option off, pin toggles, outputs pass through
        for (int i = 0; i < 6; i++)
            step("R1", 0, i[0], ~i[0], 8'(8'h11 * i), 8'(8'hA0 + i), 4'(i), 4'(~i));
        step("R7", 0, 1, 1, 8'h5A, 8'h3C, 4'h9, 4'hF);

        // R8: hold pins steady until standby sets and saturates
        for (int i = 0; i < IDLE + 3; i++)
            step("R8", 0, 0, 0, 8'h77, 8'(i), 4'h1, 4'h2);
        // R9: a single change clears standby, then it recounts
        step("R9", 0, 0, 0, 8'h78, 8'h00, 4'h1, 4'h2);
        for (int i = 0; i < IDLE + 1; i++)
            step("R9", 0, 0, 0, 8'h78, 8'h00, 4'h1, 4'h2);
        step("R9", 0, 0, 0, 8'h79, 8'h00, 4'h1, 4'h2);

        // R2 and R7: option on, raise the pin, watch entry after two edges
        step("R2", 1, 1, 1, 8'hC3, 8'hE1, 4'hA, 4'h5);
        step("R2", 1, 1, 1, 8'hC4, 8'hE2, 4'hB, 4'h6);
        step("R7", 1, 1, 1, 8'hC5, 8'hE3, 4'hC, 4'h7);
        // R3, R4, R5: vary everything while frozen
        for (int i = 0; i < IDLE + 3; i++)
            step("R3", 1, 1, i[0], 8'(8'h20 + i), 8'(8'h40 + 3 * i), 4'(i), 4'(i + 1));
        step("R4", 1, 1, 0, 8'hFF, 8'hFF, 4'hF, 4'h0);
        step("R5", 1, 1, 0, 8'h01, 8'h02, 4'h3, 4'h4);

        // R6: release; outputs live again once the sync stage clears
        for (int i = 0; i < 4; i++)
            step("R6", 1, 0, 0, 8'(8'h90 + i), 8'(8'h60 + i), 4'(i + 5), 4'(i + 2));

        // R2: short pulse of one cycle still freezes after the sync delay
        step("R2", 1, 1, 0, 8'h12, 8'h34, 4'h5, 4'h6);
        for (int i = 0; i < 4; i++)
            step("R2", 1, 0, 0, 8'(8'h13 + i), 8'(8'h35 + i), 4'(i), 4'(i));

        // R1: option dropped while pin high releases at once
        step("R1", 1, 1, 0, 8'hAA, 8'hBB, 4'hC, 4'hD);
        step("R1", 1, 1, 0, 8'hAB, 8'hBC, 4'hC, 4'hD);
        step("R1", 1, 1, 0, 8'hAC, 8'hBD, 4'hC, 4'hD);
        step("R1", 0, 1, 1, 8'hAD, 8'hBE, 4'hE, 4'hF);
        step("R1", 0, 0, 1, 8'hAE, 8'hBF, 4'hE, 4'hF);

        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule